// File: doc/BRIEF.md
# Packet Timestamp Capture Bank

This block keeps precise send and receive times for timing-protocol event packets. It watches a free-running 64-bit nanosecond count. When the receive path flags a qualifying event packet, the block copies the count into a free receive slot. When the transmit path flags one, it copies the count into the single transmit slot. Each slot then holds its value until software reads it out as two 32-bit words. The receive side has `N_SLOTS` slots (four by default). Each accepted receive event reports, one cycle later, the index of the slot that now holds its time. The receive descriptor logic writes that index back along with the packet.

Software reads a slot's low word first and its high word second. Reading the high word frees the slot, so it can be used again. A status word shows which receive slots are occupied. When every receive slot is occupied, further receive events get no timestamp and only a drop pulse is raised. The bank never frees a slot by itself, so software must empty it by reading the status word and every high word.

A transmit capture raises an interrupt when the interrupt enable bit is set. While the transmit slot is still unread, a second transmit event is discarded and recorded in a sticky overrun flag.

Top module: `ts_latch_bank`

## Requirements
- R1: After reset, and after any later reset, all of the following are zero: every receive slot is free, the transmit slot is empty, the overrun flag and the interrupt enable are clear, and `irq`, `rx_cap_vld`, `rx_drop` and `rd_data` read 0.
- R2: When `rx_evt` is high at a clock edge and a slot is free, the lowest-numbered free slot stores `time_ns` as sampled at that edge. After that same edge, `rx_cap_vld` is high for one cycle and `rx_cap_idx` holds the slot number. `rx_cap_idx` is 0 whenever `rx_cap_vld` is low.
- R3: Reading word address 0x00 returns the receive status. Bit i is 1 exactly when receive slot i holds an unread time; all other bits are 0.
- R4: For receive slot i, word address 0x10+2i returns bits 31:0 of its time and 0x11+2i returns bits 63:32. `rd_data` is valid after the clock edge at which `rd_en` is sampled. Reading the high word frees the slot and clears its status bit. Reading the low word changes nothing.
- R5: A receive event that arrives while every slot is occupied is not stored. `rx_drop` is high for one cycle after that edge, `rx_cap_vld` stays low, and the stored times stay unchanged.
- R6: If a high-word read and a receive event meet at the same edge, the read is applied first. The freed slot can take the new time at once, and the read still returns the old value.
- R7: When the transmit slot is empty, `tx_evt` stores `time_ns` in it. Address 0x02 bit 0 then reads 1. Address 0x04 returns the low word and 0x05 the high word, and reading 0x05 empties the slot.
- R8: A `tx_evt` while the transmit slot is full is discarded: the stored time is kept and the overrun flag (0x02 bit 1) is set. Reading 0x02 clears the overrun flag. A new overrun at that same edge keeps it set.
- R9: The interrupt enable is bit 0 of the control word at 0x01, which is written through `wr_en`/`wr_addr`/`wr_data` and can be read back. `irq` is high exactly while the transmit slot is full and the enable is 1.
- R10: Reading the status word and then every receive high word leaves the status at 0.
- R11: Writes to any address other than 0x01 are ignored. Reads of addresses that hold no register return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | TS_W | Current clock value in nanoseconds |
| rx_evt | input | 1 | Receive event packet seen this cycle |
| tx_evt | input | 1 | Transmit event packet sent this cycle |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register word address for reads |
| rd_data | output | TS_W/2 | Read data, valid the cycle after the strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address for writes |
| wr_data | input | TS_W/2 | Write data |
| rx_cap_vld | output | 1 | Receive time stored (one-cycle pulse) |
| rx_cap_idx | output | IDX_W | Slot that stored the receive time |
| rx_drop | output | 1 | Receive event lost because every slot was occupied |
| irq | output | 1 | Transmit capture interrupt |

## Verification
Every result of this block is registered, so each one is due in the cycle right after the edge that samples its stimulus. That covers read data, the capture flags and index, the drop pulse, and the interrupt after a transmit capture or a high-word release. The bench drives each stimulus on a falling edge, holds it across exactly one rising edge, and compares outputs on the next falling edge. Same-edge cases, such as a release meeting a new event or an overrun meeting a status read, are driven in one step, so the order of operations inside that edge is checked directly.

// File: rtl/ts_bank_pkg.sv
package ts_bank_pkg;

    // Word addresses of the register file
    localparam int unsigned REG_RX_STAT   = 0;
    localparam int unsigned REG_CTRL      = 1;
    localparam int unsigned REG_TX_STAT   = 2;
    localparam int unsigned REG_TX_LO     = 4;
    localparam int unsigned REG_TX_HI     = 5;
    localparam int unsigned REG_SLOT_BASE = 16;

    // Address of the low (hi=0) or high (hi=1) word of a receive slot
    function automatic int unsigned slot_word_addr(input int unsigned slot, input bit hi);
        return REG_SLOT_BASE + 2 * slot + (hi ? 1 : 0);
    endfunction

endpackage

// File: rtl/ts_free_pick.sv
module ts_free_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     avail,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest available slot wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ts_rx_bank.sv
module ts_rx_bank #(
    parameter int N     = 4,
    parameter int TS_W  = 64,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_ns,
    input  logic              rx_evt,
    input  logic [N-1:0]      rel_mask,
    output logic [N-1:0]      full,
    output logic [N*TS_W-1:0] ts_flat,
    output logic              cap_vld,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              drop
);

    typedef struct packed {
        logic [N-1:0][TS_W-1:0] ts;
        logic [N-1:0]           full;
        logic                   cap_vld;
        logic [IDX_W-1:0]       cap_idx;
        logic                   drop;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic [N-1:0]     held_after_rel;
    logic             slot_found;
    logic [IDX_W-1:0] slot_idx;

    // Releases from this edge's reads take effect before allocation
    assign held_after_rel = st_q.full & ~rel_mask;

    ts_free_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .avail (~held_after_rel),
        .found (slot_found),
        .idx   (slot_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.full    = held_after_rel;
        st_d.cap_vld = 1'b0;
        st_d.cap_idx = '0;
        st_d.drop    = 1'b0;
        if (rx_evt) begin
            if (slot_found) begin
                st_d.full[slot_idx] = 1'b1;
                st_d.ts[slot_idx]   = time_ns;
                st_d.cap_vld        = 1'b1;
                st_d.cap_idx        = slot_idx;
            end else begin
                st_d.drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full    = st_q.full;
    assign ts_flat = st_q.ts;
    assign cap_vld = st_q.cap_vld;
    assign cap_idx = st_q.cap_idx;
    assign drop    = st_q.drop;

endmodule

// File: rtl/ts_tx_latch.sv
module ts_tx_latch #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] time_ns,
    input  logic            tx_evt,
    input  logic            release_slot,
    input  logic            ovr_clr,
    output logic            full,
    output logic            ovr,
    output logic [TS_W-1:0] ts
);

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic            full;
        logic            ovr;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic held;

    always_comb begin
        st_d      = st_q;
        held      = st_q.full & ~release_slot;
        st_d.full = held;
        st_d.ovr  = st_q.ovr & ~ovr_clr;
        if (tx_evt) begin
            if (held) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.ts   = time_ns;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign ovr  = st_q.ovr;
    assign ts   = st_q.ts;

endmodule

// File: rtl/ts_reg_port.sv
module ts_reg_port
    import ts_bank_pkg::*;
#(
    parameter int N      = 4,
    parameter int TS_W   = 64,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N-1:0]      rx_full,
    input  logic [N*TS_W-1:0] rx_ts_flat,
    input  logic              tx_full,
    input  logic              tx_ovr,
    input  logic [TS_W-1:0]   tx_ts,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_en,
    output logic [N-1:0]      rx_rel,
    output logic              tx_rel,
    output logic              ovr_clr
);

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              irq_en;
    } port_state_t;

    port_state_t st_d, st_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[DATA_W-1:1];

    // Clear-on-read strobes
    generate
        for (genvar g = 0; g < N; g++) begin : g_rel
            assign rx_rel[g] = rd_en && (rd_addr == ADDR_W'(slot_word_addr(g, 1'b1)));
        end
    endgenerate
    assign tx_rel  = rd_en && (rd_addr == ADDR_W'(REG_TX_HI));
    assign ovr_clr = rd_en && (rd_addr == ADDR_W'(REG_TX_STAT));

    always_comb begin
        st_d         = st_q;
        st_d.rd_data = '0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(REG_RX_STAT)) begin
                st_d.rd_data = DATA_W'(rx_full);
            end
            if (rd_addr == ADDR_W'(REG_CTRL)) begin
                st_d.rd_data = DATA_W'(st_q.irq_en);
            end
            if (rd_addr == ADDR_W'(REG_TX_STAT)) begin
                st_d.rd_data = DATA_W'({tx_ovr, tx_full});
            end
            if (rd_addr == ADDR_W'(REG_TX_LO)) begin
                st_d.rd_data = tx_ts[DATA_W-1:0];
            end
            if (rd_addr == ADDR_W'(REG_TX_HI)) begin
                st_d.rd_data = tx_ts[TS_W-1:DATA_W];
            end
            for (int i = 0; i < N; i++) begin
                if (rd_addr == ADDR_W'(slot_word_addr(i, 1'b0))) begin
                    st_d.rd_data = rx_ts_flat[i*TS_W +: DATA_W];
                end
                if (rd_addr == ADDR_W'(slot_word_addr(i, 1'b1))) begin
                    st_d.rd_data = rx_ts_flat[i*TS_W+DATA_W +: DATA_W];
                end
            end
        end
        if (wr_en && (wr_addr == ADDR_W'(REG_CTRL))) begin
            st_d.irq_en = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;
    assign irq_en  = st_q.irq_en;

endmodule

// File: rtl/ts_latch_bank.sv
module ts_latch_bank #(
    parameter int N_SLOTS  = 4,
    parameter int TS_W     = 64,
    parameter int ADDR_W   = 5,
    localparam int DATA_W  = TS_W / 2,
    localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_ns,
    input  logic              rx_evt,
    input  logic              tx_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rx_cap_vld,
    output logic [IDX_W-1:0]  rx_cap_idx,
    output logic              rx_drop,
    output logic              irq
);

    logic [N_SLOTS-1:0]      rx_full;
    logic [N_SLOTS*TS_W-1:0] rx_ts_flat;
    logic [N_SLOTS-1:0]      rx_rel;
    logic                    tx_full;
    logic                    tx_ovr;
    logic [TS_W-1:0]         tx_ts;
    logic                    tx_rel;
    logic                    ovr_clr;
    logic                    irq_en;

    ts_rx_bank #(.N(N_SLOTS), .TS_W(TS_W), .IDX_W(IDX_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .time_ns  (time_ns),
        .rx_evt   (rx_evt),
        .rel_mask (rx_rel),
        .full     (rx_full),
        .ts_flat  (rx_ts_flat),
        .cap_vld  (rx_cap_vld),
        .cap_idx  (rx_cap_idx),
        .drop     (rx_drop)
    );

    ts_tx_latch #(.TS_W(TS_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .time_ns      (time_ns),
        .tx_evt       (tx_evt),
        .release_slot (tx_rel),
        .ovr_clr      (ovr_clr),
        .full         (tx_full),
        .ovr          (tx_ovr),
        .ts           (tx_ts)
    );

    ts_reg_port #(.N(N_SLOTS), .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rx_full    (rx_full),
        .rx_ts_flat (rx_ts_flat),
        .tx_full    (tx_full),
        .tx_ovr     (tx_ovr),
        .tx_ts      (tx_ts),
        .rd_data    (rd_data),
        .irq_en     (irq_en),
        .rx_rel     (rx_rel),
        .tx_rel     (tx_rel),
        .ovr_clr    (ovr_clr)
    );

    assign irq = tx_full & irq_en;

endmodule

// File: rtl/ts_latch_bank_chk.sv
module ts_latch_bank_chk
    import ts_bank_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int TS_W    = 64,
    parameter int ADDR_W  = 5,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_evt,
    input logic               tx_evt,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               wr_en,
    input logic               rx_cap_vld,
    input logic [IDX_W-1:0]   rx_cap_idx,
    input logic               rx_drop,
    input logic               irq,
    input logic               irq_en,
    input logic [N_SLOTS-1:0] rx_full,
    input logic               tx_full,
    input logic               tx_ovr,
    input logic [TS_W-1:0]    tx_ts
);

    logic hi_rd_any;
    logic tx_hi_rd;

    always_comb begin
        hi_rd_any = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (rd_en && (rd_addr == ADDR_W'(slot_word_addr(i, 1'b1)))) begin
                hi_rd_any = 1'b1;
            end
        end
    end
    assign tx_hi_rd = rd_en && (rd_addr == ADDR_W'(REG_TX_HI));

    p_cap_follows_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cap_vld |-> $past(rx_evt));

    p_cap_slot_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cap_vld |-> rx_full[rx_cap_idx]);

    p_cap_drop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_cap_vld && rx_drop));

    p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && (&rx_full) && !hi_rd_any) |=> (rx_drop && !rx_cap_vld));

    p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_hi_rd) |=> $stable(tx_ts));

    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_evt && !tx_hi_rd) |=> tx_ovr);

    p_irq_on_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt && !tx_full && irq_en && !wr_en) |=> irq);

    generate
        for (genvar g = 0; g < N_SLOTS; g++) begin : g_free
            p_hi_read_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && (rd_addr == ADDR_W'(slot_word_addr(g, 1'b1))) && !rx_evt)
                |=> !rx_full[g]);
        end
    endgenerate

endmodule

bind ts_latch_bank ts_latch_bank_chk #(
    .N_SLOTS (N_SLOTS),
    .TS_W    (TS_W),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_evt     (rx_evt),
    .tx_evt     (tx_evt),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .rx_cap_vld (rx_cap_vld),
    .rx_cap_idx (rx_cap_idx),
    .rx_drop    (rx_drop),
    .irq        (irq),
    .irq_en     (irq_en),
    .rx_full    (rx_full),
    .tx_full    (tx_full),
    .tx_ovr     (tx_ovr),
    .tx_ts      (tx_ts)
);

// File: tb/sim_ts_latch_bank.sv
module sim_ts_latch_bank;

    localparam logic [1:0] OP_RX = 2'd0;
    localparam logic [1:0] OP_TX = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;
    localparam logic [1:0] OP_WR = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [63:0] t;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // RX exp = {drop, vld, idx[1:0]}; TX/WR exp = irq; RD exp = rd_data
    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 5'h00, 64'h0, 32'h0, 4'd3},                          // R3 empty
        '{OP_RX, 5'h00, 64'h1111_0001_2222_0001, 32'h4, 4'd2},        // R2 slot0
        '{OP_RX, 5'h00, 64'h1111_0002_2222_0002, 32'h5, 4'd2},        // R2 slot1
        '{OP_RX, 5'h00, 64'h1111_0003_2222_0003, 32'h6, 4'd2},        // R2 slot2
        '{OP_RD, 5'h00, 64'h0, 32'h7, 4'd3},                          // R3
        '{OP_RD, 5'h12, 64'h0, 32'h2222_0002, 4'd4},                  // R4 low
        '{OP_RD, 5'h00, 64'h0, 32'h7, 4'd4},                          // R4 low keeps
        '{OP_RD, 5'h13, 64'h0, 32'h1111_0002, 4'd4},                  // R4 high
        '{OP_RD, 5'h00, 64'h0, 32'h5, 4'd4},                          // R4 freed
        '{OP_RX, 5'h00, 64'h1111_0004_2222_0004, 32'h5, 4'd2},        // R2 lowest free
        '{OP_RX, 5'h00, 64'h1111_0005_2222_0005, 32'h7, 4'd2},        // R2 slot3
        '{OP_RX, 5'h00, 64'h1111_0006_2222_0006, 32'h8, 4'd5},        // R5 drop
        '{OP_RD, 5'h00, 64'h0, 32'hF, 4'd5},                          // R5
        '{OP_RD, 5'h17, 64'h0, 32'h1111_0005, 4'd5},                  // R5 kept
        '{OP_TX, 5'h00, 64'hAAAA_0001_BBBB_0001, 32'h0, 4'd9},        // R9 no enable
        '{OP_RD, 5'h02, 64'h0, 32'h1, 4'd7},                          // R7
        '{OP_TX, 5'h00, 64'hAAAA_0002_BBBB_0002, 32'h0, 4'd8},        // R8 overrun
        '{OP_RD, 5'h02, 64'h0, 32'h3, 4'd8},                          // R8
        '{OP_RD, 5'h02, 64'h0, 32'h1, 4'd8},                          // R8 cleared
        '{OP_RD, 5'h04, 64'h0, 32'hBBBB_0001, 4'd8},                  // R8 kept
        '{OP_RD, 5'h05, 64'h0, 32'hAAAA_0001, 4'd7},                  // R7
        '{OP_RD, 5'h02, 64'h0, 32'h0, 4'd7},                          // R7 released
        '{OP_WR, 5'h01, 64'h1, 32'h0, 4'd9},                          // R9
        '{OP_RD, 5'h01, 64'h0, 32'h1, 4'd9},                          // R9 readback
        '{OP_TX, 5'h00, 64'hAAAA_0003_BBBB_0003, 32'h1, 4'd9},        // R9 irq
        '{OP_RD, 5'h05, 64'h0, 32'hAAAA_0003, 4'd7},                  // R7
        '{OP_RD, 5'h1F, 64'h0, 32'h0, 4'd11},                         // R11 unmapped
        '{OP_RD, 5'h00, 64'h0, 32'h7, 4'd11}                          // R11 no change
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] time_ns;
    logic        rx_evt, tx_evt, rd_en, wr_en;
    logic [4:0]  rd_addr, wr_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        rx_cap_vld, rx_drop, irq;
    logic [1:0]  rx_cap_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ts_latch_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_ns    (time_ns),
        .rx_evt     (rx_evt),
        .tx_evt     (tx_evt),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rx_cap_vld (rx_cap_vld),
        .rx_cap_idx (rx_cap_idx),
        .rx_drop    (rx_drop),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, hold over one rising edge, return at the next falling edge
    task automatic step(input logic rx, input logic tx, input logic rd, input logic wr,
                        input logic [4:0] a, input logic [63:0] t);
        rx_evt  = rx;
        tx_evt  = tx;
        rd_en   = rd;
        wr_en   = wr;
        rd_addr = a;
        wr_addr = a;
        wr_data = t[31:0];
        time_ns = t;
        @(posedge clk);
        @(negedge clk);
        rx_evt = 1'b0;
        tx_evt = 1'b0;
        rd_en  = 1'b0;
        wr_en  = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b0, a, 64'h0);
        check(tag, 64'(rd_data), 64'(exp));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rx_evt = 1'b0; tx_evt = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        rd_addr = '0; wr_addr = '0; wr_data = '0; time_ns = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 64'(irq), 64'h0);
        check("R1 rx_cap_vld", 64'(rx_cap_vld), 64'h0);
        check("R1 rx_drop", 64'(rx_drop), 64'h0);
        check("R1 rd_data", 64'(rd_data), 64'h0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VEC[k];
            case (v.op)
                OP_RX: begin
                    step(1'b1, 1'b0, 1'b0, 1'b0, v.addr, v.t);
                    check($sformatf("R%0d vec %0d rx", v.req, k),
                          64'({rx_drop, rx_cap_vld, rx_cap_idx}), 64'(v.exp));
                end
                OP_TX: begin
                    step(1'b0, 1'b1, 1'b0, 1'b0, v.addr, v.t);
                    check($sformatf("R%0d vec %0d irq", v.req, k), 64'(irq), 64'(v.exp));
                end
                OP_RD: begin
                    step(1'b0, 1'b0, 1'b1, 1'b0, v.addr, v.t);
                    check($sformatf("R%0d vec %0d rd", v.req, k), 64'(rd_data), 64'(v.exp));
                end
                default: begin
                    step(1'b0, 1'b0, 1'b0, 1'b1, v.addr, v.t);
                    check($sformatf("R%0d vec %0d wr irq", v.req, k), 64'(irq), 64'(v.exp));
                end
            endcase
        end

        // R9: irq drops after the transmit high word was read
        check("R9 irq after release", 64'(irq), 64'h0);

        // R6: high read of slot0 meets a receive event at the same edge
        step(1'b1, 1'b0, 1'b1, 1'b0, 5'h11, 64'h1111_0007_2222_0007);
        check("R6 old value returned", 64'(rd_data), 64'h1111_0001);
        check("R6 freed slot reused", 64'({rx_drop, rx_cap_vld, rx_cap_idx}), 64'h4);
        rd(5'h10, 32'h2222_0007, "R6 new low word");

        // R10: status then every high word empties the bank
        rd(5'h00, 32'h7, "R10 status before");
        rd(5'h11, 32'h1111_0007, "R10 slot0 high");
        rd(5'h13, 32'h1111_0004, "R10 slot1 high");
        rd(5'h15, 32'h1111_0003, "R4 slot2 high");
        rd(5'h17, 32'h0000_0000 | 32'h1111_0005, "R10 slot3 high");
        rd(5'h00, 32'h0, "R10 status after");

        // R11: write to a non-control address ignored
        step(1'b0, 1'b0, 1'b0, 1'b1, 5'h00, 64'hF);
        rd(5'h00, 32'h0, "R11 status unchanged");
        rd(5'h01, 32'h1, "R11 ctrl unchanged");

        // R8: overrun at the same edge as a status read stays set
        step(1'b0, 1'b1, 1'b0, 1'b0, 5'h00, 64'hCCCC_0001_DDDD_0001);
        step(1'b0, 1'b1, 1'b1, 1'b0, 5'h02, 64'hCCCC_0002_DDDD_0002);
        check("R8 status at same-edge overrun", 64'(rd_data), 64'h1);
        rd(5'h02, 32'h3, "R8 overrun kept");

        // R1: reset in mid-run clears everything
        step(1'b1, 1'b0, 1'b0, 1'b0, 5'h00, 64'h5);
        check("R9 irq before reset", 64'(irq), 64'h1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 64'(irq), 64'h0);
        check("R1 cap after reset", 64'(rx_cap_vld), 64'h0);
        rd(5'h00, 32'h0, "R1 status after reset");
        rd(5'h02, 32'h0, "R1 tx status after reset");
        rd(5'h01, 32'h0, "R1 ctrl after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule